// File: doc/BRIEF.md
# Pattern-Based Word Boundary Aligner

This block sits behind a deserializer whose parallel words start at an arbitrary bit position. It keeps the previously accepted word and joins it to the current one to form a window twice the word width. It compares a programmable alignment pattern against that window at every bit offset in a single cycle. When the pattern is found, the block remembers its offset and from then on emits words cut from the window at that offset, so the pattern lands on bit 0 of an output word. Bit 0 of every word is the bit received first.

Two lock policies exist. In automatic mode every accepted word that contains the pattern moves the boundary to the lowest matching offset. In manual mode the boundary is frozen until a rising edge on the request pin arms the aligner, which then locks on the first pattern seen and disarms. A run-length monitor watches the raw incoming bit stream and flags any run of identical bits that is longer than a programmable limit.

Both data sides use valid/ready. A word is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. An output word stays on `m_data` unchanged while `m_valid` is high and `m_ready` is low. Configuration and status pins carry no handshake.

Top module: `word_aligner`

## Requirements
- R1: After reset `m_valid`, `realign` and `rl_viol` are 0, `s_ready` is 1, the held offset is 0 and the aligner is unlocked.
- R2: `s_ready` equals `!m_valid || m_ready`. While `m_valid && !m_ready`, `m_data` and `m_pat` hold their values. When no word is accepted and `m_ready` is 1, `m_valid` falls on the next clock.
- R3: For each accepted word, the output word, visible one clock later, is bits [o+W-1:o] of {current word, previous accepted word}, where o is the offset after this word's decision. The previous word reads as 0 until the first word after reset has been accepted, and no pattern search happens for that first word.
- R4: `pat_len_sel` picks the pattern length: 0=7, 1=8, 2=10, 3=16, 4=20 and 5=32 bits, with codes 6 and 7 treated as 32. Only the low bits of `pattern` up to that length are compared, and higher bits have no effect.
- R5: In automatic mode (`mode_manual`=0), any accepted word whose window matches at some offset 0..W-1 sets the held offset to the matching offset.
- R6: When several offsets match in the same window, the lowest one is taken.
- R7: In manual mode, a rising edge of `align_req` (a 0 to 1 change between consecutive clocks) arms the aligner. The first accepted word with a match, in that cycle or later, sets the offset and disarms.
- R8: In manual mode while unarmed, patterns at any offset leave the held offset unchanged.
- R9: `m_pat` is 1 on an output word exactly when the pattern matches at the offset used to cut that word.
- R10: `realign` is a one-clock pulse, issued with the output word, when a lock sets an offset different from the held one, or on the first lock after reset. A lock at the already held offset gives no pulse.
- R11: The run counter counts consecutive identical bits of accepted words, continuing across word edges and restarting at 1 on every bit change. `rl_viol` is 1 for one clock after an accepted word in which the count went above `rl_limit`.
- R12: A run whose length equals `rl_limit` does not raise `rl_viol`, and a run one bit longer does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word |
| s_data | input | W | Unaligned word from the deserializer, bit 0 first |
| m_valid | output | 1 | Aligned word valid |
| m_ready | input | 1 | Consumer accepts the aligned word |
| m_data | output | W | Aligned word |
| m_pat | output | 1 | Output word starts with the pattern |
| realign | output | 1 | Pulse when the boundary changes |
| mode_manual | input | 1 | 0 selects automatic, 1 selects manual lock |
| align_req | input | 1 | Rising edge arms a manual lock |
| pat_len_sel | input | 3 | Pattern length code |
| pattern | input | 32 | Alignment pattern value, low bits used |
| rl_limit | input | 6 | Longest allowed run of identical bits |
| rl_viol | output | 1 | Run-length violation seen in the last accepted word |

## Verification
On every cycle, the assertions check that the output stays frozen under back-pressure, that the held offset cannot move in manual mode without an arming edge, that the priority grant is one-hot within the requests, and that a realign pulse only comes with a pattern-flagged word. Only the directed scenarios can show the actual cut positions and the choice of the lowest offset among several matches. They also cover the masking of pattern bits above the selected length, the arm-once behaviour of manual mode, and run-length counting across word edges at exactly the limit and one bit past it.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int PMAX = 32;

  typedef enum logic [2:0] {
    PLEN_7  = 3'd0,
    PLEN_8  = 3'd1,
    PLEN_10 = 3'd2,
    PLEN_16 = 3'd3,
    PLEN_20 = 3'd4,
    PLEN_32 = 3'd5
  } plen_e;

  function automatic logic [PMAX-1:0] plen_mask(input logic [2:0] sel);
    logic [PMAX-1:0] m;
    case (sel)
      PLEN_7:  m = 32'h0000_007F;
      PLEN_8:  m = 32'h0000_00FF;
      PLEN_10: m = 32'h0000_03FF;
      PLEN_16: m = 32'h0000_FFFF;
      PLEN_20: m = 32'h000F_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wa_match.sv
module wa_match
  import wa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0]  window,
  input  logic [PMAX-1:0] pattern,
  input  logic [2:0]      len_sel,
  output logic [W-1:0]    hits
);
  localparam int EXT = 2*W + PMAX;

  logic [EXT-1:0]  ext;
  logic [PMAX-1:0] mask;

  assign ext  = {{PMAX{1'b0}}, window};
  assign mask = plen_mask(len_sel);

  for (genvar o = 0; o < W; o++) begin : g_off
    assign hits[o] = (((ext[o +: PMAX] ^ pattern) & mask) == '0);
  end
endmodule

// File: rtl/wa_prio.sv
module wa_prio #(
  parameter int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0) && (any == (req != '0)));
endmodule

// File: rtl/wa_runlen.sv
module wa_runlen #(
  parameter int W  = 32,
  parameter int LW = 6,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [W-1:0]  data,
  input  logic [LW-1:0] limit,
  output logic          viol
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          last_q, started_q, viol_q;
  logic [CW-1:0] cnt_q;
  logic          last_n, started_n, viol_n;
  logic [CW-1:0] cnt_n;

  always_comb begin
    last_n    = last_q;
    started_n = started_q;
    cnt_n     = cnt_q;
    viol_n    = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (started_n && (data[i] == last_n)) begin
        if (cnt_n != CMAX) cnt_n = cnt_n + 1'b1;
      end else begin
        cnt_n = CW'(1);
      end
      last_n    = data[i];
      started_n = 1'b1;
      if (cnt_n > {1'b0, limit}) viol_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
      viol_q    <= 1'b0;
    end else begin
      viol_q <= fire && viol_n;
      if (fire) begin
        last_q    <= last_n;
        started_q <= started_n;
        cnt_q     <= cnt_n;
      end
    end
  end

  assign viol = viol_q;

  a_r11_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (cnt_q != '0));
endmodule

// File: rtl/word_aligner.sv
module word_aligner
  import wa_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [W-1:0]    s_data,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [W-1:0]    m_data,
  output logic            m_pat,
  output logic            realign,
  input  logic            mode_manual,
  input  logic            align_req,
  input  logic [2:0]      pat_len_sel,
  input  logic [PMAX-1:0] pattern,
  input  logic [LW-1:0]   rl_limit,
  output logic            rl_viol
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]   prev_q;
  logic           have_prev_q, locked_q, armed_q, req_q;
  logic [IW-1:0]  off_q;
  logic           m_valid_q, m_pat_q, realign_q;
  logic [W-1:0]   m_data_q;

  logic           fire;
  logic [2*W-1:0] window;
  logic [W-1:0]   hits, grant;
  logic [IW-1:0]  low_idx;
  logic           hit_any, req_rise, armed_eff, may_lock;
  logic [IW-1:0]  off_next;

  assign s_ready = !m_valid_q || m_ready;
  assign fire    = s_valid && s_ready;
  assign window  = {s_data, prev_q};

  wa_match #(.W(W)) u_match (
    .window  (window),
    .pattern (pattern),
    .len_sel (pat_len_sel),
    .hits    (hits)
  );

  logic prio_any;
  wa_prio #(.N(W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (hits),
    .grant (grant),
    .idx   (low_idx),
    .any   (prio_any)
  );

  wa_runlen #(.W(W), .LW(LW)) u_runlen (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .data  (s_data),
    .limit (rl_limit),
    .viol  (rl_viol)
  );

  assign hit_any   = prio_any && have_prev_q;
  assign req_rise  = align_req && !req_q;
  assign armed_eff = armed_q || req_rise;
  assign may_lock  = hit_any && (!mode_manual || armed_eff);
  assign off_next  = may_lock ? low_idx : off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      locked_q    <= 1'b0;
      armed_q     <= 1'b0;
      req_q       <= 1'b0;
      off_q       <= '0;
    end else begin
      req_q <= align_req;
      if (fire && may_lock) armed_q <= 1'b0;
      else                  armed_q <= armed_eff;
      if (fire) begin
        prev_q      <= s_data;
        have_prev_q <= 1'b1;
        off_q       <= off_next;
        if (may_lock) locked_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
      m_pat_q   <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      realign_q <= fire && may_lock && (!locked_q || (low_idx != off_q));
      if (fire) begin
        m_valid_q <= 1'b1;
        m_data_q  <= window[off_next +: W];
        m_pat_q   <= have_prev_q && hits[off_next];
      end else if (m_ready) begin
        m_valid_q <= 1'b0;
      end
    end
  end

  assign m_valid = m_valid_q;
  assign m_data  = m_data_q;
  assign m_pat   = m_pat_q;
  assign realign = realign_q;

  a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_pat)));

  a_r8_manual_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_manual && !armed_eff) |=> $stable(off_q));

  a_r10_realign_with_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> (m_pat && m_valid));

  a_r3_no_lock_without_history: assert property (@(posedge clk) disable iff (!rst_n)
    !have_prev_q |=> !realign);
endmodule

// File: tb/tb_word_aligner.sv
module tb_word_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [W-1:0]  s_data = '0;
  logic          m_valid;
  logic          m_ready = 1'b1;
  logic [W-1:0]  m_data;
  logic          m_pat;
  logic          realign;
  logic          mode_manual = 1'b0;
  logic          align_req = 1'b0;
  logic [2:0]    pat_len_sel = 3'd2;
  logic [31:0]   pattern = 32'h17C;
  logic [5:0]    rl_limit = 6'd63;
  logic          rl_viol;

  int checks = 0;
  int failures = 0;

  localparam logic [31:0] P10 = 32'h17C;

  word_aligner #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_pat(m_pat), .realign(realign), .mode_manual(mode_manual),
    .align_req(align_req), .pat_len_sel(pat_len_sel), .pattern(pattern),
    .rl_limit(rl_limit), .rl_viol(rl_viol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic man, input logic [2:0] lsel,
                          input logic [31:0] pat, input logic [5:0] lim);
    @(negedge clk);
    rst_n = 1'b0;
    s_valid = 1'b0;
    m_ready = 1'b1;
    align_req = 1'b0;
    mode_manual = man;
    pat_len_sel = lsel;
    pattern = pat;
    rl_limit = lim;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [31:0] w);
    s_valid = 1'b1;
    s_data = w;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0, 3'd2, P10, 6'd63);
    check("R1 m_valid", 32'(m_valid), 0);
    check("R1 realign", 32'(realign), 0);
    check("R1 rl_viol", 32'(rl_viol), 0);
    check("R1 s_ready", 32'(s_ready), 1);
  endtask

  task automatic t_auto;
    do_reset(1'b0, 3'd2, P10, 6'd63);
    push(32'h0);
    push(P10 << 5);
    push(32'h0);
    check("R5 lock data", m_data, P10);
    check("R9 pat flag", 32'(m_pat), 1);
    check("R10 first lock pulse", 32'(realign), 1);
    push(32'h3);
    check("R3 held offset cut", m_data, 32'h1800_0000);
    check("R9 no pattern", 32'(m_pat), 0);
    check("R10 pulse one clock", 32'(realign), 0);
    push(P10 << 5);
    push(32'h0);
    check("R10 same offset no pulse", 32'(realign), 0);
    check("R9 same offset flag", 32'(m_pat), 1);
    push(P10 << 9);
    push(32'h0);
    check("R5 move offset", m_data, P10);
    check("R10 new offset pulse", 32'(realign), 1);
  endtask

  task automatic t_lowest;
    do_reset(1'b0, 3'd1, 32'hA5, 6'd63);
    push(32'h0);
    push((32'hA5 << 2) | (32'hA5 << 12));
    push(32'h0);
    check("R6 lowest offset data", m_data, 32'h0002_94A5);
    check("R6 flag", 32'(m_pat), 1);
  endtask

  task automatic t_len32;
    do_reset(1'b0, 3'd5, 32'hDEAD_BEEF, 6'd63);
    push(32'h0);
    push(32'hDEAD_BEEF << 4);
    push(32'hDEAD_BEEF >> 28);
    check("R4 len32 data", m_data, 32'hDEAD_BEEF);
    check("R4 len32 flag", 32'(m_pat), 1);
  endtask

  task automatic t_len7_mask;
    do_reset(1'b0, 3'd0, 32'hFFFF_FFDB, 6'd63);
    push(32'h0);
    push(32'h5B << 9);
    push(32'h0);
    check("R4 len7 upper bits ignored data", m_data, 32'h5B);
    check("R4 len7 flag", 32'(m_pat), 1);
  endtask

  task automatic t_manual;
    do_reset(1'b1, 3'd2, P10, 6'd63);
    push(32'h0);
    push(P10 << 3);
    push(32'h0);
    check("R8 unarmed no lock data", m_data, P10 << 3);
    check("R8 unarmed no flag", 32'(m_pat), 0);
    check("R8 unarmed no pulse", 32'(realign), 0);
    align_req = 1'b1;
    push(32'h0);
    push(P10 << 7);
    push(32'h0);
    check("R7 armed lock data", m_data, P10);
    check("R7 armed lock pulse", 32'(realign), 1);
    push(P10 << 12);
    push(32'h0);
    check("R8 disarmed keeps offset", m_data, P10 << 5);
    check("R8 disarmed no flag", 32'(m_pat), 0);
    check("R8 disarmed no pulse", 32'(realign), 0);
    push(P10 << 7);
    push(32'h0);
    check("R9 held offset flag", 32'(m_pat), 1);
    align_req = 1'b0;
  endtask

  task automatic t_runlen;
    do_reset(1'b0, 3'd2, P10, 6'd5);
    push(32'h5555_5555);
    check("R11 alternating", 32'(rl_viol), 0);
    push(32'h5555_5F55);
    check("R12 run equal limit", 32'(rl_viol), 0);
    push(32'h5555_3F55);
    check("R12 run limit plus one", 32'(rl_viol), 1);
    push(32'hF555_5555);
    check("R11 run of four at top", 32'(rl_viol), 0);
    push(32'h5555_5553);
    check("R11 run across word edge", 32'(rl_viol), 1);
  endtask

  task automatic t_backpressure;
    do_reset(1'b0, 3'd2, P10, 6'd63);
    m_ready = 1'b0;
    push(32'h0F0F_0F0F);
    check("R2 valid after accept", 32'(m_valid), 1);
    check("R2 ready low when full", 32'(s_ready), 0);
    s_valid = 1'b1;
    s_data = 32'h1111_0000;
    repeat (3) @(negedge clk);
    check("R2 data held", m_data, 32'h0);
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R3 next word cut at offset 0", m_data, 32'h0F0F_0F0F);
    @(negedge clk);
    check("R2 valid drops when drained", 32'(m_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_auto();
    t_lowest();
    t_len32();
    t_len7_mask();
    t_manual();
    t_runlen();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule